// File: doc/BRIEF.md
# ADC Conversion Control Register Unit

This block holds the software-visible control bits for a successive-approximation converter and sequences its conversions. A CPU writes two 8-bit registers through a simple write port and reads them back through a combinational read port. The unit divides the system clock into an ADC clock tick, runs a conversion timer measured in ADC clock ticks, and reports completion through a sticky flag and a gated interrupt request.

A conversion starts when software writes one to the start bit, or, with automatic triggering enabled, on a rising edge of one trigger input picked by a 4-bit select field. The first conversion after reset is a longer calibration conversion. The analog core, the result data path and reference selection lie outside this unit. The conversion-done pulse drives the result capture and the tick output paces the analog core.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, the control register (read address 0), the trigger register (read address 1) and `irq` all read 0.
- R2: Writing 1 to control bit 6 while idle starts a conversion. Bit 6 reads 1 while a conversion is running and returns to 0 by itself when it ends. Writing 0 to bit 6 starts nothing and stops nothing.
- R3: The first conversion after reset lasts INIT_CYC ADC clock ticks (default 25). Every later conversion lasts NORM_CYC ticks (default 13). `conv_done` is high for exactly the last system clock cycle of a conversion.
- R4: Control bits 2:0 choose the ADC clock period in system clocks: codes 0 and 1 give 2, and code k (k ≥ 2) gives 2^k. A conversion therefore stays busy for ticks × period system clocks, and `adc_tick` pulses once per period while busy.
- R5: When control bit 5 is 1, a rising edge on `trig_i[s]` starts a conversion, where s is trigger-register bits 3:0. Edges on other inputs, select values s ≥ NUM_TRIG, edges while busy, and any edge while bit 5 is 0 start nothing.
- R6: Control bit 4 (the flag) becomes 1 at the clock edge that ends a conversion, and it is never set at any other time.
- R7: The flag is cleared by writing 1 to control bit 4 or by pulsing `irq_ack`. Writing 0 to bit 4 leaves it unchanged.
- R8: If a clear (write or `irq_ack`) arrives in the same cycle as a conversion end, the flag is 1 afterwards.
- R9: `irq` is high exactly when the flag and control bit 3 (interrupt enable) are both 1.
- R10: Trigger-register bit 7 is a high-speed enable, mirrored on `hs_mode`. Bits 3:0 hold the trigger select. Bits 6:4 and control bit 7 always read 0.
- R11: Writing 1 to the start bit while busy neither restarts nor lengthens the running conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 trigger register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 trigger register |
| rd_data | output | 8 | Read data for `rd_addr` |
| trig_i | input | NUM_TRIG | Automatic trigger sources |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | End-of-conversion interrupt request |
| conv_done | output | 1 | High in the final cycle of a conversion |
| adc_tick | output | 1 | One pulse per ADC clock period while busy |
| hs_mode | output | 1 | High-speed mode enable |

## Verification
The bench builds the unit with NUM_TRIG set to 12 and the default conversion lengths of 13 and 25 ticks. With 12 sources, select values 12 to 15 point at no input, so the rule that out-of-range selects never start a conversion can be exercised. The default lengths and the prescale codes 0, 1, 2, 3 and 7 produce busy windows from 26 to 1664 system clocks. Each window is counted against the product of ticks and period, and the model also confirms that the 25-tick calibration conversion happens only once after reset.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int SRC_W     = 4;
    localparam int SRC_SLOTS = 1 << SRC_W;
    localparam int DIV_MAX   = 128;
    localparam int CNT_W     = $clog2(DIV_MAX);

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_TRIG = 1'b1
    } reg_sel_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_CONV = 1'b1
    } seq_state_e;

    // control register image; bit positions are software visible
    typedef struct packed {
        logic       rsvd;
        logic       start;
        logic       auto_en;
        logic       flag;
        logic       ie;
        logic [2:0] ps;
    } ctrl_a_t;

    // trigger register image
    typedef struct packed {
        logic             hs;
        logic [2:0]       rsvd;
        logic [SRC_W-1:0] src;
    } ctrl_b_t;

    // ADC clock period in system clocks for a prescale code
    function automatic logic [CNT_W:0] div_of(input logic [2:0] code);
        if (code <= 3'd1) return (CNT_W+1)'(2);
        return (CNT_W+1)'(1) << code;
    endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
    import adc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   period;

    assign period = div_of(code);
    // >= keeps ticking if the code shrinks mid-count
    assign tick   = run && ({1'b0, cnt} >= period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R4

endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_TRIG = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRIG-1:0] trig_i,
    input  logic [SRC_W-1:0]    sel,
    output logic                hit_o
);
    logic [NUM_TRIG-1:0]  prev;
    logic [NUM_TRIG-1:0]  rise;
    logic [SRC_SLOTS-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= trig_i;
    end

    assign rise = trig_i & ~prev;

    for (genvar g = 0; g < SRC_SLOTS; g++) begin : g_slot
        if (g < NUM_TRIG) begin : g_live
            assign slot[g] = rise[g];
        end else begin : g_dead
            assign slot[g] = 1'b0;
        end
    end

    assign hit_o = slot[sel];

    AST_HIT_IS_EDGE: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> ($past(sel) != sel) || !hit_o);  // R5

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_ctrl_pkg::*;
#(
    parameter int NORM_CYC = 13,
    parameter int INIT_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic tick_i,
    output logic busy_o,
    output logic done_o
);
    localparam int MAX_CYC = (NORM_CYC > INIT_CYC) ? NORM_CYC : INIT_CYC;
    localparam int REM_W   = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    logic [REM_W-1:0] rem;
    logic             first;

    assign busy_o = (state == S_CONV);
    assign done_o = busy_o && tick_i && (rem == REM_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            rem   <= '0;
            first <= 1'b1;
        end else begin
            unique case (state)
                S_IDLE: if (start_i) begin
                    state <= S_CONV;
                    rem   <= first ? REM_W'(INIT_CYC) : REM_W'(NORM_CYC);
                end
                S_CONV: if (tick_i) begin
                    if (rem == REM_W'(1)) begin
                        state <= S_IDLE;
                        first <= 1'b0;
                    end
                    rem <= rem - 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !start_i) |=> state == S_IDLE);  // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == S_CONV && !done_o) |=> state == S_CONV);  // R11
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (state == S_CONV && start_i && !tick_i) |=> $stable(rem));  // R11
    AST_REM_RANGE: assert property (@(posedge clk) disable iff (rst)
        state == S_CONV |-> (rem != '0 && rem <= REM_W'(MAX_CYC)));  // R3

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int NUM_TRIG = 16,
    parameter int NORM_CYC = 13,
    parameter int INIT_CYC = 25
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                rd_addr,
    output logic [7:0]          rd_data,
    input  logic [NUM_TRIG-1:0] trig_i,
    input  logic                irq_ack,
    output logic                irq,
    output logic                conv_done,
    output logic                adc_tick,
    output logic                hs_mode
);
    ctrl_a_t          wa;
    ctrl_b_t          wb;
    ctrl_a_t          ra;
    ctrl_b_t          rb;
    logic             wr_a;
    logic             wr_b;
    logic             auto_en_q;
    logic             ie_q;
    logic [2:0]       ps_q;
    logic             flag_q;
    logic             hs_q;
    logic [SRC_W-1:0] src_q;
    logic             trig_hit;
    logic             start;
    logic             busy;
    logic             flag_clr;
    logic             unused_wr_bits;

    assign wa   = ctrl_a_t'(wr_data);
    assign wb   = ctrl_b_t'(wr_data);
    assign wr_a = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);
    assign wr_b = wr_en && (reg_sel_e'(wr_addr) == REG_TRIG);
    assign unused_wr_bits = ^{wa.rsvd, wb.rsvd};

    adc_trig_edge #(.NUM_TRIG(NUM_TRIG)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_i),
        .sel    (src_q),
        .hit_o  (trig_hit)
    );

    assign start = (wr_a && wa.start) || (auto_en_q && trig_hit);

    adc_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .code (ps_q),
        .tick (adc_tick)
    );

    adc_conv_seq #(.NORM_CYC(NORM_CYC), .INIT_CYC(INIT_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .tick_i  (adc_tick),
        .busy_o  (busy),
        .done_o  (conv_done)
    );

    assign flag_clr = (wr_a && wa.flag) || irq_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_en_q <= 1'b0;
            ie_q      <= 1'b0;
            ps_q      <= '0;
            flag_q    <= 1'b0;
            hs_q      <= 1'b0;
            src_q     <= '0;
        end else begin
            if (wr_a) begin
                auto_en_q <= wa.auto_en;
                ie_q      <= wa.ie;
                ps_q      <= wa.ps;
            end
            if (wr_b) begin
                hs_q  <= wb.hs;
                src_q <= wb.src;
            end
            // completion outranks a clear in the same cycle
            if (conv_done)     flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    always_comb begin
        ra         = '0;
        ra.start   = busy;
        ra.auto_en = auto_en_q;
        ra.flag    = flag_q;
        ra.ie      = ie_q;
        ra.ps      = ps_q;
        rb         = '0;
        rb.hs      = hs_q;
        rb.src     = src_q;
    end

    assign rd_data = (reg_sel_e'(rd_addr) == REG_TRIG) ? rb : ra;
    assign irq     = flag_q && ie_q;
    assign hs_mode = hs_q;

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> flag_q);  // R8
    AST_FLAG_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !conv_done) |=> !flag_q);  // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q);  // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !busy);  // R2

endmodule

// File: tb/tb_adc_conv_ctrl.sv
module tb_adc_conv_ctrl;
    localparam int NT   = 12;
    localparam int NORM = 13;
    localparam int INIT = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_addr = 1'b0;
    logic [7:0]    rd_data;
    logic [NT-1:0] trig_i = '0;
    logic          irq_ack = 1'b0;
    logic          irq, conv_done, adc_tick, hs_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    bit m_busy, m_auto, m_flag, m_ie, m_hs, m_first;
    int m_ps, m_src, m_rem, m_div, m_el;
    bit [NT-1:0] m_prev;

    adc_conv_ctrl #(.NUM_TRIG(NT), .NORM_CYC(NORM), .INIT_CYC(INIT)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .trig_i(trig_i), .irq_ack(irq_ack),
        .irq(irq), .conv_done(conv_done), .adc_tick(adc_tick), .hs_mode(hs_mode)
    );

    always #2.5 clk = ~clk;

    function automatic int period_of(int code);
        return (code <= 1) ? 2 : (1 << code);
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit wa, wb, hit, done_now, start;
        if (rst) begin
            m_busy = 0; m_auto = 0; m_flag = 0; m_ie = 0; m_hs = 0; m_first = 1;
            m_ps = 0; m_src = 0; m_rem = 0; m_div = 2; m_el = 0; m_prev = '0;
            return;
        end
        wa = wr_en && !wr_addr;
        wb = wr_en && wr_addr;
        hit = (m_src < NT) && trig_i[m_src] && !m_prev[m_src];
        done_now = m_busy && (m_rem == 1);
        start = !m_busy && ((wa && wr_data[6]) || (m_auto && hit));
        if (done_now) begin
            m_busy = 0; m_flag = 1; m_first = 0;
        end else if (m_busy) begin
            m_rem--; m_el++;
        end else if (start) begin
            m_div  = period_of(wa ? int'(wr_data[2:0]) : m_ps);
            m_rem  = (m_first ? INIT : NORM) * m_div;
            m_busy = 1; m_el = 0;
        end
        if (!done_now && ((wa && wr_data[4]) || irq_ack)) m_flag = 0;
        if (wa) begin
            m_auto = wr_data[5]; m_ie = wr_data[3]; m_ps = int'(wr_data[2:0]);
        end
        if (wb) begin
            m_hs = wr_data[7]; m_src = int'(wr_data[3:0]);
        end
        m_prev = trig_i;
    endtask

    // model advanced on every edge, outputs compared 1 ns later
    always @(posedge clk) begin
        model_step();
        #1;
        if (!finished) begin
            if (rd_addr)
                chk(rd_data, {m_hs, 3'b000, 4'(m_src)}, "R10 trigger register");
            else
                chk(rd_data, {1'b0, m_busy, m_auto, m_flag, m_ie, 3'(m_ps)}, "R2/R6 control register");
            chk(irq, m_flag && m_ie, "R9 irq");
            chk(conv_done, m_busy && (m_rem == 1), "R3 conv_done");
            chk(adc_tick, m_busy && ((m_el % m_div) == m_div - 1), "R4 adc_tick");
            chk(hs_mode, m_hs, "R10 hs_mode");
        end
    end

    task automatic wr(input bit a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts busy cycles; optionally pokes a start write (kind 0) or a trig[5] edge (kind 1)
    task automatic measure(input int exp, input int poke_at, input int kind, input string tag);
        int n = 0;
        while (rd_data[6]) begin
            n++;
            wr_en  = (kind == 0) && (n == poke_at);
            wr_addr = 1'b0;
            if (kind == 0 && n == poke_at) wr_data = 8'h41;
            trig_i = (kind == 1 && n == poke_at) ? NT'(1 << 5) : '0;
            @(negedge clk);
        end
        wr_en = 1'b0; trig_i = '0;
        chk(n, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data, 0, "R1 control after reset");
        chk(irq, 0, "R1 irq after reset");
        rd_addr = 1'b1; #1;
        chk(rd_data, 0, "R1 trigger register after reset");
        rd_addr = 1'b0;
        @(negedge clk);

        wr(0, 8'h48);
        measure(INIT * 2, 0, 0, "R3 calibration length code 0");
        chk(rd_data[4], 1, "R6 flag after end");
        chk(irq, 1, "R9 irq with enable");

        wr(0, 8'h08);
        chk(rd_data[4], 1, "R7 zero write keeps flag");
        chk(rd_data[6], 0, "R2 zero write starts nothing");
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk(rd_data[4], 0, "R7 ack clears flag");
        chk(irq, 0, "R9 irq low after ack");

        wr(0, 8'h41);
        measure(NORM * 2, 5, 0, "R11 restart ignored code 1");
        chk(irq, 0, "R9 flag set but disabled");
        wr(0, 8'h10);
        chk(rd_data[4], 0, "R7 write one clears flag");

        wr(0, 8'h43);
        measure(NORM * 8, 0, 0, "R4 code 3");
        wr(0, 8'h47);
        measure(NORM * 128, 0, 0, "R4 code 7");
        wr(0, 8'h42);
        measure(NORM * 4, 0, 0, "R4 code 2");

        wr(0, 8'h4A);
        while (!conv_done) begin @(posedge clk); #1; end
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h1A; irq_ack = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; irq_ack = 1'b0;
        chk(rd_data[4], 1, "R8 set beats clear");
        wr(0, 8'h1A);

        wr(1, 8'hFF);
        rd_addr = 1'b1; #1;
        chk(rd_data, 8'h8F, "R10 reserved bits read zero");
        chk(hs_mode, 1, "R10 hs_mode set");
        rd_addr = 1'b0;
        wr(1, 8'h05);

        wr(0, 8'h2A);
        trig_i = NT'(1 << 6); @(negedge clk); trig_i = '0; @(negedge clk);
        chk(rd_data[6], 0, "R5 unselected source");
        trig_i = NT'(1 << 5); @(negedge clk);
        chk(rd_data[6], 1, "R5 selected edge starts");
        measure(NORM * 4, 8, 1, "R5 retrigger while busy ignored");

        wr(1, 8'h0D);
        trig_i = '1; @(negedge clk); trig_i = '0; @(negedge clk);
        chk(rd_data[6], 0, "R5 select out of range");

        wr(1, 8'h05);
        wr(0, 8'h0A);
        trig_i = NT'(1 << 5); @(negedge clk); trig_i = '0; @(negedge clk);
        chk(rd_data[6], 0, "R5 auto disabled");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule